// File: doc/BRIEF.md
# Programmed-image checksum engine

This engine produces the 16-bit verification sum of a programmed memory image. After a start pulse it walks the user program space from address zero upward, reading one word per cycle through a read port whose data returns one cycle after the address. It adds every returned word to two configuration words, each masked by its own constant. Carries out of bit 15 are dropped.

When the first configuration word marks the image as protected, the engine does not touch memory. It adds a 16-bit value packed from the low nibbles of four identification words to the masked configuration words. The result stays on the checksum output, and a one-cycle done pulse marks it valid. The configuration words, identification words and size selection are captured on the cycle the start is accepted.

Top module: `img_checksum`

## Requirements
- R1: While reset is low and on the first cycle after it, done is 0, checksum is 0x0000 and mem_rd is 0.
- R2: In unprotected mode the engine reads addresses 0 up to 0x0FFF when size_8k is 0, or 0x1FFF when it is 1. It reads each address exactly once, in ascending order, one per cycle with mem_rd high, and adds each mem_data word returned on the following cycle.
- R3: Only the bits of cfg_a selected by 0x39FF contribute to the sum.
- R4: Only the bits of cfg_b selected by 0x0043 contribute to the sum.
- R5: The checksum is the total modulo 65536.
- R6: Protected mode applies when bit 13 of cfg_a is 0. In that mode mem_rd stays 0 and the sum is the two masked configuration words plus the packed ID value.
- R7: The packed ID value is {id0[3:0], id1[3:0], id2[3:0], id3[3:0]}, with id0 in bits 15:12. IDs 1, 2, 3, 4 give 0x1234.
- R8: For an unprotected image in which every word is 0x3FFF, with cfg_a = cfg_b = 0x3FFF, the checksum is 0x2A42 for 4K words and 0x1A42 for 8K words.
- R9: done is high for one cycle. In unprotected mode that cycle comes N+1 cycles after the start edge, where N is the word count. In protected mode it is the cycle right after the start edge. The checksum then holds until the next accepted start.
- R10: A start during a run is ignored. A start in the cycle in which done is high is accepted and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation when idle |
| size_8k | input | 1 | 1 selects 8K words, 0 selects 4K words |
| cfg_a | input | 14 | First configuration word (bit 13 = 0 means protected) |
| cfg_b | input | 14 | Second configuration word |
| id0 | input | 14 | Identification word 0 |
| id1 | input | 14 | Identification word 1 |
| id2 | input | 14 | Identification word 2 |
| id3 | input | 14 | Identification word 3 |
| mem_rd | output | 1 | Read strobe to program memory |
| mem_addr | output | 13 | Read address |
| mem_data | input | 14 | Read data, valid one cycle after the strobe |
| done | output | 1 | One-cycle result-valid pulse |
| checksum | output | 16 | Result |

## Verification
A run can finish in the same cycle that a new start arrives, so completion and acceptance of the next start can coincide. The bench raises start in the very cycle it sees done. It then checks that the second run produces its own independently computed sum and its own done latency, for both an unprotected and a protected follow-up. The bench also raises start in the middle of a run with different inputs and checks that the first result is unaffected.

// File: rtl/img_checksum.sv
module img_checksum #(
  parameter int AW     = 13,
  parameter int DW     = 14,
  parameter int SW     = 16,
  parameter logic [DW-1:0] MASK_A = 14'h39FF,
  parameter logic [DW-1:0] MASK_B = 14'h0043,
  parameter int PROT_BIT = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          size_8k,
  input  logic [DW-1:0] cfg_a,
  input  logic [DW-1:0] cfg_b,
  input  logic [DW-1:0] id0,
  input  logic [DW-1:0] id1,
  input  logic [DW-1:0] id2,
  input  logic [DW-1:0] id3,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_data,
  output logic          done,
  output logic [SW-1:0] checksum
);
  localparam logic [AW-1:0] LAST_BIG   = {AW{1'b1}};
  localparam logic [AW-1:0] LAST_SMALL = LAST_BIG >> 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_t;

  state_t        st;
  logic [AW-1:0] addr;
  logic          pend;
  logic          size_q;
  logic [SW-1:0] acc;
  logic          done_r;

  logic          busy;
  logic          prot;
  logic [AW-1:0] last;
  logic [SW-1:0] base;
  logic [SW-1:0] id_pack;

  assign busy     = (st != S_IDLE);
  assign prot     = ~cfg_a[PROT_BIT];
  assign last     = size_q ? LAST_BIG : LAST_SMALL;
  assign id_pack  = {id0[3:0], id1[3:0], id2[3:0], id3[3:0]};
  assign base     = SW'(cfg_a & MASK_A) + SW'(cfg_b & MASK_B);

  assign mem_rd   = (st == S_RUN);
  assign mem_addr = addr;
  assign done     = done_r;
  assign checksum = acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr   <= '0;
      pend   <= 1'b0;
      size_q <= 1'b0;
      acc    <= '0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      pend   <= (st == S_RUN);
      if (pend) acc <= acc + SW'(mem_data);
      unique case (st)
        S_IDLE: if (start) begin
          size_q <= size_8k;
          addr   <= '0;
          if (prot) begin
            acc    <= base + id_pack;
            done_r <= 1'b1;
          end else begin
            acc <= base;
            st  <= S_RUN;
          end
        end
        S_RUN: begin
          if (addr == last) st <= S_DRAIN;
          else addr <= addr + 1'b1;
        end
        S_DRAIN: begin
          st     <= S_IDLE;
          done_r <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module img_checksum_chk #(
  parameter int AW = 13,
  parameter int DW = 14,
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [DW-1:0] cfg_a,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic [SW-1:0] checksum,
  input logic          busy,
  input logic          size_q
);
  AST_PROT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !cfg_a[13]) |=> !mem_rd); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R2
  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !$past(mem_rd)) |-> (mem_addr == '0)); // R2
  AST_SMALL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !size_q) |-> !mem_addr[AW-1]); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_rd); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(checksum)); // R9
endmodule

bind img_checksum img_checksum_chk #(.AW(AW), .DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_a(cfg_a),
  .mem_rd(mem_rd), .mem_addr(mem_addr), .done(done), .checksum(checksum),
  .busy(busy), .size_q(size_q)
);

// File: tb/img_checksum_tb.sv
module img_checksum_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        size_8k = 1'b0;
  logic [13:0] cfg_a = '0, cfg_b = '0, id0 = '0, id1 = '0, id2 = '0, id3 = '0;
  logic        mem_rd;
  logic [12:0] mem_addr;
  logic [13:0] mem_data = '0;
  logic        done;
  logic [15:0] checksum;

  int n_chk = 0;
  int n_bad = 0;
  int pat   = 0;
  int rd_cnt = 0;
  int seq_err = 0;
  logic [12:0] prev_addr = '0;

  always #2 clk = ~clk;

  img_checksum u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .size_8k(size_8k),
    .cfg_a(cfg_a), .cfg_b(cfg_b), .id0(id0), .id1(id1), .id2(id2), .id3(id3),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
    .done(done), .checksum(checksum)
  );

  function automatic logic [13:0] word_at(int a, int p);
    if (p == 0) return 14'h3FFF;
    return 14'(((a * p) ^ (a >> 3)) + p);
  endfunction

  always @(posedge clk) if (mem_rd) mem_data <= word_at(int'(mem_addr), pat);

  always @(negedge clk) if (mem_rd) begin
    if (rd_cnt == 0 && mem_addr != 0) seq_err++;
    if (rd_cnt != 0 && mem_addr != prev_addr + 1'b1) seq_err++;
    prev_addr = mem_addr;
    rd_cnt++;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(logic [13:0] a, logic [13:0] b,
      logic [13:0] i0, logic [13:0] i1, logic [13:0] i2, logic [13:0] i3,
      logic big, int p);
    logic [15:0] s;
    s = 16'(a & 14'h39FF) + 16'(b & 14'h0043);
    if (!a[13]) s = s + {i0[3:0], i1[3:0], i2[3:0], i3[3:0]};
    else for (int k = 0; k < (big ? 8192 : 4096); k++) s = s + 16'(word_at(k, p));
    return s;
  endfunction

  // Launches at the current negedge, returns at the negedge where done is seen.
  task automatic run(string req, logic [13:0] a, logic [13:0] b,
      logic [13:0] i0, logic [13:0] i1, logic [13:0] i2, logic [13:0] i3,
      logic big, int p, output logic [15:0] res);
    int cyc = 0;
    int words = big ? 8192 : 4096;
    pat = p; cfg_a = a; cfg_b = b; id0 = i0; id1 = i1; id2 = i2; id3 = i3;
    size_8k = big; rd_cnt = 0; seq_err = 0;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    res = checksum;
    check({req, " R9 latency"}, cyc, a[13] ? words + 1 : 0);
    check({req, " R2 read count"}, rd_cnt, a[13] ? words : 0);
    check({req, " R2 address order"}, seq_err, 0);
    check({req, " sum"}, checksum, model(a, b, i0, i1, i2, i3, big, p));
  endtask

  task automatic t_reset();
    check("R1 done", done, 0);
    check("R1 checksum", checksum, 0);
    check("R1 mem_rd", mem_rd, 0);
  endtask

  task automatic t_blank();
    logic [15:0] r;
    run("R8 blank 4K", 14'h3FFF, 14'h3FFF, 0, 0, 0, 0, 1'b0, 0, r);
    check("R8 blank 4K value", r, 16'h2A42);
    @(negedge clk);
    run("R8 blank 8K", 14'h3FFF, 14'h3FFF, 0, 0, 0, 0, 1'b1, 0, r);
    check("R8 blank 8K value", r, 16'h1A42);
    @(negedge clk);
  endtask

  task automatic t_masks();
    logic [15:0] r;
    // bits 10,9 of cfg_a and non-mask bits of cfg_b must not contribute
    run("R3 R4 R5 pattern 4K", 14'h2600, 14'h3FBC, 0, 0, 0, 0, 1'b0, 7, r);
    run("R3 R4 R5 pattern 8K", 14'h3FFF, 14'h0043, 0, 0, 0, 0, 1'b1, 13, r);
    @(negedge clk);
  endtask

  task automatic t_protected();
    logic [15:0] r;
    run("R6 R7 protected", 14'h1FFF, 14'h3FFF, 14'h3FF1, 14'h3FF2, 14'h3FF3, 14'h3FF4,
        1'b1, 5, r);
    check("R7 packed id value", r, 16'h19FF + 16'h0043 + 16'h1234);
    @(negedge clk);
    check("R9 done one cycle", done, 0);
    repeat (5) @(negedge clk);
    check("R9 result held", checksum, r);
  endtask

  task automatic t_ignore();
    logic [15:0] exp_v = model(14'h3FFF, 14'h0001, 0, 0, 0, 0, 1'b0, 3);
    rd_cnt = 0; seq_err = 0; pat = 3;
    cfg_a = 14'h3FFF; cfg_b = 14'h0001; size_8k = 1'b0;
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    cfg_a = 14'h0000; cfg_b = 14'h3FFF; size_8k = 1'b1; id0 = 14'hF;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check("R10 busy start ignored sum", checksum, exp_v);
    check("R10 busy start ignored reads", rd_cnt, 4096);
    @(negedge clk);
  endtask

  task automatic t_chained();
    logic [15:0] r;
    run("R10 first", 14'h3FFF, 14'h0042, 0, 0, 0, 0, 1'b0, 9, r);
    run("R10 restart in done cycle", 14'h3FFF, 14'h0003, 0, 0, 0, 0, 1'b0, 11, r);
    run("R10 protected restart", 14'h0ABC, 14'h0041, 14'h5, 14'hA, 14'h0, 14'hF, 1'b0, 2, r);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_blank();
    t_masks();
    t_protected();
    t_ignore();
    t_chained();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule